// File: doc/BRIEF.md
# Two-Phase Fetch/Execute Sequencer

This block sequences a small processor whose instructions and data live in one single-ported memory. Each instruction uses two clock cycles. A single phase bit alternates between an instruction-fetch cycle and an execute cycle. In the fetch cycle the shared memory is addressed by the program counter, and the instruction register loads. In the execute cycle the memory is addressed by the ALU result, and the architectural state (PC, register file, memory) may change. The cost is a fixed CPI of 2.

The phase outputs are combined with a combinational opcode decoder. The decoder produces the write-back source, ALU operand-B source, immediate extension mode, destination-register select and ALU mode. It also produces the register-write and memory-write strobes, which only pass in the execute phase. The program counter lives in the block. At the end of every execute cycle the PC advances by 4, or it loads a target address supplied by the datapath when a jump is decoded or a taken equality branch is decoded. The datapath, register file and memory sit outside the block and drive `op_code`, `alu_zero` and `jump_target`.

The phase machine has two states: FETCH and EXEC. The transition ISSUE goes from FETCH to EXEC, and the transition RETIRE goes from EXEC back to FETCH. The reset transition forces FETCH from either state.

Top module: `fetch_exec_ctl`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high at a rising edge, the next cycle is in the FETCH phase (`phase_exec`=0) with `pc`=0.
- R2: Out of reset, `phase_exec` toggles on every rising edge, so each instruction occupies exactly one FETCH and one EXEC cycle (CPI of 2).
- R3: In FETCH, `ir_en`=1, `pc_en`=0, `mem_addr_alu`=0 (the PC addresses memory), and `rf_we`=`mem_we`=0 whatever the opcode is.
- R4: In EXEC, `ir_en`=0, `pc_en`=1 and `mem_addr_alu`=1 (the ALU result addresses memory).
- R5: `rf_we` is 1 only in EXEC, and only for opcode 0x00 (register ALU op), 0x08 (add immediate) or 0x23 (load).
- R6: `mem_we` is 1 only in EXEC, and only for opcode 0x2B (store).
- R7: The PC changes only at the edge that ends an EXEC cycle. It loads `jump_target` for opcode 0x02 (jump), or for opcode 0x04 (branch-if-equal) with `alu_zero`=1. Otherwise it loads PC+4. `alu_zero` has no effect on any other opcode.
- R8: The decoder sets these selects in both phases. `wb_from_mem`=1 only for load. `alu_b_imm`=1 for load, store and add immediate. `imm_sign_ext`=1 for load, store, add immediate and branch. `dest_is_rd`=1 only for the register ALU op. `alu_mode` is 0 (add) for load, store, add immediate, jump and unknown opcodes, 1 (subtract) for branch, and 2 (function field) for the register ALU op.
- R9: Any opcode other than the six listed acts as a no-op: no register or memory write, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| jump_target | input | AW | Branch/jump target computed by the datapath |
| phase_exec | output | 1 | 0 = FETCH, 1 = EXEC |
| mem_addr_alu | output | 1 | Memory address select: 0 = PC, 1 = ALU result |
| ir_en | output | 1 | Instruction register load enable |
| pc_en | output | 1 | PC update enable |
| rf_we | output | 1 | Register file write strobe |
| mem_we | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Write-back source: 0 = ALU, 1 = memory |
| alu_b_imm | output | 1 | ALU operand B: 0 = register, 1 = immediate |
| imm_sign_ext | output | 1 | Immediate extension: 0 = zero, 1 = sign |
| dest_is_rd | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| alu_mode | output | 2 | 0 add, 1 subtract, 2 function field |
| pc | output | AW | Program counter |

## Verification
The decoder is tried with every defined opcode and with an unused opcode. Each one is presented during both FETCH and EXEC, which separates gating by the phase from decoding of the opcode. Branch-if-equal is applied with the zero flag both low and high, to separate a taken branch from a fall-through. The register ALU op and store are also applied with the zero flag high, to show that the flag only matters for branches. A jump to address 0 and a reset asserted during EXEC show that the target is loaded as given and that reset wins over a PC update that is pending.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    localparam int OP_W = 6;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_FUNCT = 2'd2,
        ALU_RSVD  = 2'd3
    } alu_mode_e;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    typedef struct packed {
        logic      rf_wr;
        logic      mem_wr;
        logic      wb_mem;
        logic      b_imm;
        logic      ext_sign;
        logic      dst_rd;
        logic      is_beq;
        logic      is_jump;
        alu_mode_e alu_mode;
    } dec_t;

endpackage

// File: rtl/fxc_phase_fsm.sv
module fxc_phase_fsm
    import fxc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase,
    output logic   ir_load,
    output logic   pc_load,
    output logic   addr_from_alu,
    output logic   commit_ok
);

    phase_e phase_q;
    phase_e phase_d;

    // next-state: ISSUE (FETCH->EXEC), RETIRE (EXEC->FETCH)
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_FETCH: phase_d = PH_EXEC;
            PH_EXEC:  phase_d = PH_FETCH;
            default:  phase_d = PH_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= phase_d;
    end

    // phase outputs
    always_comb begin
        ir_load       = 1'b0;
        pc_load       = 1'b0;
        addr_from_alu = 1'b0;
        commit_ok     = 1'b0;
        unique case (phase_q)
            PH_FETCH: begin
                ir_load = 1'b1;
            end
            PH_EXEC: begin
                pc_load       = 1'b1;
                addr_from_alu = 1'b1;
                commit_ok     = 1'b1;
            end
            default: ;
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/fxc_op_decode.sv
module fxc_op_decode
    import fxc_pkg::*;
(
    input  logic [OP_W-1:0] opc,
    output dec_t            dec
);

    always_comb begin
        dec          = '0;
        dec.alu_mode = ALU_ADD;
        unique case (opc)
            OPC_RTYPE: begin
                dec.rf_wr    = 1'b1;
                dec.dst_rd   = 1'b1;
                dec.alu_mode = ALU_FUNCT;
            end
            OPC_ADDI: begin
                dec.rf_wr    = 1'b1;
                dec.b_imm    = 1'b1;
                dec.ext_sign = 1'b1;
            end
            OPC_LOAD: begin
                dec.rf_wr    = 1'b1;
                dec.wb_mem   = 1'b1;
                dec.b_imm    = 1'b1;
                dec.ext_sign = 1'b1;
            end
            OPC_STORE: begin
                dec.mem_wr   = 1'b1;
                dec.b_imm    = 1'b1;
                dec.ext_sign = 1'b1;
            end
            OPC_BEQ: begin
                dec.is_beq   = 1'b1;
                dec.ext_sign = 1'b1;
                dec.alu_mode = ALU_SUB;
            end
            OPC_JUMP: begin
                dec.is_jump  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fxc_next_pc.sv
module fxc_next_pc #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc_q
);

    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] seq_pc;
    logic [AW-1:0] pc_d;

    assign seq_pc = pc_q + INC;
    assign pc_d   = redirect ? target : seq_pc;

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (load) pc_q <= pc_d;
    end

endmodule

// File: rtl/fetch_exec_ctl.sv
module fetch_exec_ctl
    import fxc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [5:0]      op_code,
    input  logic            alu_zero,
    input  logic [AW-1:0]   jump_target,
    output logic            phase_exec,
    output logic            mem_addr_alu,
    output logic            ir_en,
    output logic            pc_en,
    output logic            rf_we,
    output logic            mem_we,
    output logic            wb_from_mem,
    output logic            alu_b_imm,
    output logic            imm_sign_ext,
    output logic            dest_is_rd,
    output logic [1:0]      alu_mode,
    output logic [AW-1:0]   pc
);

    phase_e phase;
    logic   commit_ok;
    dec_t   dec;
    logic   redirect;

    fxc_phase_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .phase         (phase),
        .ir_load       (ir_en),
        .pc_load       (pc_en),
        .addr_from_alu (mem_addr_alu),
        .commit_ok     (commit_ok)
    );

    fxc_op_decode u_dec (
        .opc (op_code),
        .dec (dec)
    );

    assign redirect = dec.is_jump | (dec.is_beq & alu_zero);

    fxc_next_pc #(.AW(AW), .STEP(4)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_en),
        .redirect (redirect),
        .target   (jump_target),
        .pc_q     (pc)
    );

    assign phase_exec   = (phase == PH_EXEC);
    assign rf_we        = dec.rf_wr  & commit_ok;
    assign mem_we       = dec.mem_wr & commit_ok;
    assign wb_from_mem  = dec.wb_mem;
    assign alu_b_imm    = dec.b_imm;
    assign imm_sign_ext = dec.ext_sign;
    assign dest_is_rd   = dec.dst_rd;
    assign alu_mode     = dec.alu_mode;

endmodule

// File: rtl/fxc_checker.sv
module fxc_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [5:0]    op_code,
    input logic          phase_exec,
    input logic          mem_addr_alu,
    input logic          ir_en,
    input logic          pc_en,
    input logic          rf_we,
    input logic          mem_we,
    input logic [AW-1:0] pc
);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (pc == '0 && !phase_exec));

    assert_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
        !phase_exec |=> phase_exec);

    assert_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        phase_exec |=> !phase_exec);

    assert_fetch_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        !phase_exec |-> (ir_en && !pc_en && !mem_addr_alu && !rf_we && !mem_we));

    assert_exec_ctl_R4: assert property (@(posedge clk) disable iff (rst)
        phase_exec |-> (!ir_en && pc_en && mem_addr_alu));

    assert_rf_we_R5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (phase_exec && (op_code == 6'h00 || op_code == 6'h08 || op_code == 6'h23)));

    assert_mem_we_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase_exec && op_code == 6'h2B));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !phase_exec |=> $stable(pc));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_exec && op_code != 6'h02 && op_code != 6'h04) |=> (pc == $past(pc) + AW'(4)));

endmodule

bind fetch_exec_ctl fxc_checker #(.AW(AW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .op_code      (op_code),
    .phase_exec   (phase_exec),
    .mem_addr_alu (mem_addr_alu),
    .ir_en        (ir_en),
    .pc_en        (pc_en),
    .rf_we        (rf_we),
    .mem_we       (mem_we),
    .pc           (pc)
);

// File: tb/fetch_exec_ctl_tb_top.sv
module fetch_exec_ctl_tb_top;

    localparam int AW = 32;
    localparam int NV = 12;

    typedef struct packed {
        logic [5:0]    op;
        logic          zero;
        logic [AW-1:0] tgt;
        logic          rfw;
        logic          mw;
        logic          take;
        logic          wb;
        logic          bimm;
        logic          ext;
        logic          dst;
        logic [1:0]    alu;
    } vec_t;

    // op, zero, target, rf_we, mem_we, take, wb, bimm, ext, dst, alu
    localparam vec_t VECS [NV] = '{
        '{6'h00, 1'b0, 32'h100,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
        '{6'h08, 1'b1, 32'h100,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{6'h23, 1'b0, 32'h100,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        '{6'h2B, 1'b0, 32'h100,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{6'h04, 1'b0, 32'h40,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{6'h04, 1'b1, 32'h80,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{6'h02, 1'b0, 32'h200,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{6'h3F, 1'b1, 32'h10,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{6'h00, 1'b1, 32'h300,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
        '{6'h2B, 1'b1, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0},
        '{6'h02, 1'b1, 32'h0,    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{6'h23, 1'b0, 32'h500,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    op_code = '0;
    logic          alu_zero = 1'b0;
    logic [AW-1:0] jump_target = '0;
    logic          phase_exec, mem_addr_alu, ir_en, pc_en, rf_we, mem_we;
    logic          wb_from_mem, alu_b_imm, imm_sign_ext, dest_is_rd;
    logic [1:0]    alu_mode;
    logic [AW-1:0] pc;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    fetch_exec_ctl #(.AW(AW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .op_code      (op_code),
        .alu_zero     (alu_zero),
        .jump_target  (jump_target),
        .phase_exec   (phase_exec),
        .mem_addr_alu (mem_addr_alu),
        .ir_en        (ir_en),
        .pc_en        (pc_en),
        .rf_we        (rf_we),
        .mem_we       (mem_we),
        .wb_from_mem  (wb_from_mem),
        .alu_b_imm    (alu_b_imm),
        .imm_sign_ext (imm_sign_ext),
        .dest_is_rd   (dest_is_rd),
        .alu_mode     (alu_mode),
        .pc           (pc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [AW-1:0] exp_pc;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 phase after reset", 64'(phase_exec), 64'(0));
        check("R1 pc after reset", 64'(pc), 64'(0));
        exp_pc = '0;

        for (int i = 0; i < NV; i++) begin
            // FETCH cycle: opcode already present, writes must stay off
            op_code     = VECS[i].op;
            alu_zero    = VECS[i].zero;
            jump_target = VECS[i].tgt;
            #1;
            check("R3 fetch controls", {phase_exec, ir_en, pc_en, mem_addr_alu},
                  {1'b0, 1'b1, 1'b0, 1'b0});
            check("R3 fetch writes gated", {rf_we, mem_we}, 2'b00);
            check("R8 selects in fetch",
                  {wb_from_mem, alu_b_imm, imm_sign_ext, dest_is_rd, alu_mode},
                  {VECS[i].wb, VECS[i].bimm, VECS[i].ext, VECS[i].dst, VECS[i].alu});
            @(negedge clk);
            #1;
            check("R4 exec controls", {phase_exec, ir_en, pc_en, mem_addr_alu},
                  {1'b1, 1'b0, 1'b1, 1'b1});
            check("R5 rf_we in exec", 64'(rf_we), 64'(VECS[i].rfw));
            check("R6 mem_we in exec", 64'(mem_we), 64'(VECS[i].mw));
            check("R2 pc held during exec", 64'(pc), 64'(exp_pc));
            exp_pc = VECS[i].take ? VECS[i].tgt : exp_pc + 32'd4;
            @(negedge clk);
            #1;
            if (VECS[i].op == 6'h3F)
                check("R9 unknown opcode pc step", 64'(pc), 64'(exp_pc));
            else
                check("R7 next pc", 64'(pc), 64'(exp_pc));
        end

        // R1: reset asserted during EXEC of a jump beats the PC update
        op_code = 6'h02; jump_target = 32'h700; alu_zero = 1'b0;
        @(negedge clk);
        #1;
        check("R2 in exec before reset", 64'(phase_exec), 64'(1));
        rst = 1'b1;
        @(negedge clk);
        #1;
        check("R1 reset from exec phase", 64'(phase_exec), 64'(0));
        check("R1 reset clears pc", 64'(pc), 64'(0));
        rst = 1'b0;
        op_code = 6'h2B;
        #1;
        check("R6 store in fetch after reset", 64'(mem_we), 64'(0));
        @(negedge clk);
        #1;
        check("R6 store in exec after reset", 64'(mem_we), 64'(1));
        @(negedge clk);
        #1;
        check("R7 pc after store", 64'(pc), 64'(4));

        finish_run();
    end

endmodule